// File: doc/BRIEF.md
# Custom-Precision Floating-Point Multiplier

This block multiplies two floating-point numbers of a small, freely chosen format and returns their product with a wider fraction. Each operand is a packed word. Its top two bits are a class tag. Below the tag sit a sign bit, a biased exponent of `WE` bits and a fraction of `WF` bits. The significand of a normal number is 1.f, and subnormal values do not exist. Special values are carried only by the class tag, never by reserved exponent codes.

The result keeps the exponent width and widens the fraction. With `EXTENDED = 0` the fraction is `WF+1` bits, rounded to nearest with ties to even. With `EXTENDED = 1` it is `2*WF+1` bits, which holds the exact product of two `WF+1`-bit significands. The circuit is purely combinational and has no clock and no registers. A surrounding datapath places it between its own pipeline stages as its timing requires. There is no handshake on either side, because the block holds no state that could apply back-pressure.

Top module: `cfp_multiplier`

## Requirements
- R1: Operands are packed from the MSB down as tag[1:0], sign, exponent[WE-1:0], fraction[WF-1:0]. The result uses the same order with a fraction of WF+1 bits (EXTENDED=0) or 2*WF+1 bits (EXTENDED=1). The defaults are WE=5, WF=2, EXTENDED=0, which give a 10-bit operand and an 11-bit result.
- R2: Tag codes are 00 zero, 01 normal, 10 infinity and 11 NaN. For two normal operands the result exponent is ea + eb - (2^(WE-1)-1). When the significand product is 2.0 or more, 1 is added to the exponent and the product is shifted right by one place before the fraction is taken.
- R3: With EXTENDED=0 the discarded product bits are rounded to nearest with ties to even, and the result fraction is the WF+1 bits below the leading one.
- R4: When rounding carries out of the fraction, the fraction becomes zero and the exponent rises by one.
- R5: With EXTENDED=1 the result fraction is the exact 2*WF+1-bit product below the leading one, with no rounding.
- R6: A final exponent above 2^WE-1 gives tag 10 (infinity).
- R7: A final exponent below 0 gives tag 00 (zero). A final exponent of exactly 0 or exactly 2^WE-1 is a normal result.
- R8: A NaN operand gives NaN. Zero times infinity gives NaN.
- R9: Infinity times a normal or infinite value gives infinity. Zero times a normal or zero value gives zero. The exponent and fraction bits of an operand whose tag is not 01 are ignored. Every non-normal result has all exponent and fraction bits zero.
- R10: The result sign is the XOR of the operand signs for every tag combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WE+WF+3 | First operand, packed as in R1 |
| op_b | input | WE+WF+3 | Second operand, packed as in R1 |
| result | output | WE+3+(EXTENDED ? 2*WF+1 : WF+1) | Product, packed as in R1 |

## Verification
The bound checker watches the class-level rules whenever the inputs change. These rules are NaN dominance, zero times infinity, the sign XOR, a normal result only from two normal operands, and cleared fields in every non-normal result. The numeric content of a normal result cannot be checked that way without restating the datapath. The vector table, run against three configurations, is what shows it: the exponent arithmetic, the normalisation step, the ties-to-even decisions, a rounding carry into the exponent, the exact extended fraction, and the exponent boundaries at 0 and 2^WE-1.

// File: rtl/cfp_mul_pkg.sv
package cfp_mul_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NORM = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } cfp_class_e;

  function automatic int unsigned res_frac_w(input int unsigned wf, input bit ext);
    return ext ? (2 * wf + 1) : (wf + 1);
  endfunction

endpackage

// File: rtl/cfp_class_resolve.sv
module cfp_class_resolve
  import cfp_mul_pkg::*;
(
  input  logic [1:0] cls_a,
  input  logic [1:0] cls_b,
  output logic       both_normal,
  output logic [1:0] special_cls
);

  logic any_nan, any_inf, any_zero;

  always_comb begin
    any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
    any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
    any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
    both_normal = (cls_a == CLS_NORM) && (cls_b == CLS_NORM);
    if (any_nan || (any_inf && any_zero))
      special_cls = CLS_NAN;
    else if (any_inf)
      special_cls = CLS_INF;
    else if (any_zero)
      special_cls = CLS_ZERO;
    else
      special_cls = CLS_NORM;
  end

endmodule

// File: rtl/cfp_sig_product.sv
module cfp_sig_product #(
  parameter int unsigned WF = 2
) (
  input  logic [WF-1:0]   frac_a,
  input  logic [WF-1:0]   frac_b,
  output logic [2*WF:0]   frac_exact,
  output logic            norm_up
);

  localparam int unsigned SW = WF + 1;
  localparam int unsigned PW = 2 * SW;

  logic [SW-1:0] sig_a, sig_b;
  logic [PW-1:0] prod, aligned;

  always_comb begin
    sig_a   = {1'b1, frac_a};
    sig_b   = {1'b1, frac_b};
    prod    = PW'(sig_a) * PW'(sig_b);
    norm_up = prod[PW-1];
    aligned = norm_up ? prod : (prod << 1);
    frac_exact = aligned[PW-2:0];
  end

endmodule

// File: rtl/cfp_frac_round.sv
module cfp_frac_round #(
  parameter int unsigned WF       = 2,
  parameter bit          EXTENDED = 1'b0,
  localparam int unsigned RW      = cfp_mul_pkg::res_frac_w(WF, EXTENDED)
) (
  input  logic [2*WF:0] frac_exact,
  output logic [RW-1:0] frac_out,
  output logic          carry_out
);

  generate
    if (EXTENDED) begin : g_exact
      assign frac_out  = frac_exact;
      assign carry_out = 1'b0;
    end else begin : g_rne
      logic [WF:0] kept;
      logic        guard, sticky, lsb, bump;
      logic [WF+1:0] sum;
      if (WF >= 2) begin : g_sticky
        assign sticky = |frac_exact[WF-2:0];
      end else begin : g_nosticky
        assign sticky = 1'b0;
      end
      always_comb begin
        kept  = frac_exact[2*WF:WF];
        guard = frac_exact[WF-1];
        lsb   = kept[0];
        bump  = guard && (sticky || lsb);
        sum   = {1'b0, kept} + {{(WF+1){1'b0}}, bump};
      end
      assign frac_out  = sum[WF:0];
      assign carry_out = sum[WF+1];
    end
  endgenerate

endmodule

// File: rtl/cfp_multiplier.sv
module cfp_multiplier
  import cfp_mul_pkg::*;
#(
  parameter int unsigned WE       = 5,
  parameter int unsigned WF       = 2,
  parameter bit          EXTENDED = 1'b0
) (
  input  logic [WE+WF+2:0]                           op_a,
  input  logic [WE+WF+2:0]                           op_b,
  output logic [WE+2+res_frac_w(WF, EXTENDED):0]     result
);

  localparam int unsigned RW   = res_frac_w(WF, EXTENDED);
  localparam int unsigned XW   = WE + 2;
  localparam int unsigned BIAS = (1 << (WE - 1)) - 1;
  localparam int unsigned EMAX = (1 << WE) - 1;

  logic [1:0]    cls_a, cls_b, special_cls, out_cls;
  logic          sgn;
  logic [WE-1:0] exp_a, exp_b, out_exp;
  logic [WF-1:0] fr_a, fr_b;
  logic          both_normal, norm_up, rnd_carry;
  logic [2*WF:0] frac_exact;
  logic [RW-1:0] frac_rnd, out_frac;
  logic [XW-1:0] exp_biased, exp_unb;
  logic          ovf, unf;

  assign cls_a = op_a[WE+WF+2:WE+WF+1];
  assign cls_b = op_b[WE+WF+2:WE+WF+1];
  assign exp_a = op_a[WE+WF-1:WF];
  assign exp_b = op_b[WE+WF-1:WF];
  assign fr_a  = op_a[WF-1:0];
  assign fr_b  = op_b[WF-1:0];
  assign sgn   = op_a[WE+WF] ^ op_b[WE+WF];

  cfp_class_resolve u_cls (
    .cls_a       (cls_a),
    .cls_b       (cls_b),
    .both_normal (both_normal),
    .special_cls (special_cls)
  );

  cfp_sig_product #(.WF(WF)) u_sig (
    .frac_a     (fr_a),
    .frac_b     (fr_b),
    .frac_exact (frac_exact),
    .norm_up    (norm_up)
  );

  cfp_frac_round #(.WF(WF), .EXTENDED(EXTENDED)) u_rnd (
    .frac_exact (frac_exact),
    .frac_out   (frac_rnd),
    .carry_out  (rnd_carry)
  );

  always_comb begin
    exp_biased = XW'(exp_a) + XW'(exp_b) + XW'(norm_up) + XW'(rnd_carry);
    unf        = exp_biased < XW'(BIAS);
    exp_unb    = exp_biased - XW'(BIAS);
    ovf        = !unf && (exp_unb > XW'(EMAX));
    out_cls  = special_cls;
    out_exp  = '0;
    out_frac = '0;
    if (both_normal) begin
      if (ovf) begin
        out_cls = CLS_INF;
      end else if (unf) begin
        out_cls = CLS_ZERO;
      end else begin
        out_cls  = CLS_NORM;
        out_exp  = exp_unb[WE-1:0];
        out_frac = frac_rnd;
      end
    end
  end

  assign result = {out_cls, sgn, out_exp, out_frac};

endmodule

// File: rtl/cfp_multiplier_chk.sv
module cfp_multiplier_chk
  import cfp_mul_pkg::*;
#(
  parameter int unsigned WE       = 5,
  parameter int unsigned WF       = 2,
  parameter bit          EXTENDED = 1'b0
) (
  input logic [WE+WF+2:0]                       op_a,
  input logic [WE+WF+2:0]                       op_b,
  input logic [WE+2+res_frac_w(WF, EXTENDED):0] result
);

  localparam int unsigned RW = res_frac_w(WF, EXTENDED);
  localparam int unsigned OW = WE + 3 + RW;

  logic [1:0] ca, cb, cr;
  assign ca = op_a[WE+WF+2:WE+WF+1];
  assign cb = op_b[WE+WF+2:WE+WF+1];
  assign cr = result[OW-1:OW-2];

  always_comb begin
    if (ca == CLS_NAN || cb == CLS_NAN)
      AST_NAN_WINS: assert (cr == CLS_NAN); // R8
    if ((ca == CLS_ZERO && cb == CLS_INF) || (ca == CLS_INF && cb == CLS_ZERO))
      AST_ZERO_TIMES_INF: assert (cr == CLS_NAN); // R8
    AST_SIGN_XOR: assert (result[OW-3] == (op_a[WE+WF] ^ op_b[WE+WF])); // R10
    if (cr == CLS_NORM)
      AST_NORMAL_SOURCES: assert (ca == CLS_NORM && cb == CLS_NORM); // R2
    if (cr != CLS_NORM)
      AST_SPECIAL_CLEAR: assert (result[OW-4:0] == '0); // R9
  end

endmodule

bind cfp_multiplier cfp_multiplier_chk #(.WE(WE), .WF(WF), .EXTENDED(EXTENDED)) chk_i (
  .op_a   (op_a),
  .op_b   (op_b),
  .result (result)
);

// File: tb/cfp_multiplier_tb_top.sv
module cfp_multiplier_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [9:0]  a = '0, b = '0;
  logic [10:0] r_s;
  logic [12:0] r_x;
  logic [10:0] a3 = '0, b3 = '0;
  logic [11:0] r_w;

  int checks = 0;
  int fails  = 0;

  cfp_multiplier dut_i (.op_a(a), .op_b(b), .result(r_s));
  cfp_multiplier #(.EXTENDED(1'b1)) dut_x (.op_a(a), .op_b(b), .result(r_x));
  cfp_multiplier #(.WF(3)) dut_w (.op_a(a3), .op_b(b3), .result(r_w));

  // {op_a, op_b, single result, extended result}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {2'b01,1'b0,5'd15,2'b00, 2'b01,1'b0,5'd15,2'b00, 2'b01,1'b0,5'd15,3'b000, 2'b01,1'b0,5'd15,5'b00000},
    {2'b01,1'b0,5'd15,2'b10, 2'b01,1'b0,5'd15,2'b10, 2'b01,1'b0,5'd16,3'b001, 2'b01,1'b0,5'd16,5'b00100},
    {2'b01,1'b0,5'd15,2'b11, 2'b01,1'b0,5'd15,2'b11, 2'b01,1'b0,5'd16,3'b100, 2'b01,1'b0,5'd16,5'b10001},
    {2'b01,1'b1,5'd10,2'b01, 2'b01,1'b0,5'd12,2'b11, 2'b01,1'b1,5'd8, 3'b001, 2'b01,1'b1,5'd8, 5'b00011},
    {2'b01,1'b0,5'd15,2'b01, 2'b01,1'b0,5'd15,2'b01, 2'b01,1'b0,5'd15,3'b100, 2'b01,1'b0,5'd15,5'b10010},
    {2'b01,1'b1,5'd15,2'b10, 2'b01,1'b1,5'd15,2'b11, 2'b01,1'b0,5'd16,3'b010, 2'b01,1'b0,5'd16,5'b01010},
    {2'b01,1'b0,5'd30,2'b00, 2'b01,1'b0,5'd30,2'b00, 2'b10,1'b0,5'd0, 3'b000, 2'b10,1'b0,5'd0, 5'b00000},
    {2'b01,1'b0,5'd23,2'b00, 2'b01,1'b0,5'd23,2'b00, 2'b01,1'b0,5'd31,3'b000, 2'b01,1'b0,5'd31,5'b00000},
    {2'b01,1'b0,5'd23,2'b10, 2'b01,1'b0,5'd23,2'b10, 2'b10,1'b0,5'd0, 3'b000, 2'b10,1'b0,5'd0, 5'b00000},
    {2'b01,1'b0,5'd8, 2'b00, 2'b01,1'b0,5'd7, 2'b00, 2'b01,1'b0,5'd0, 3'b000, 2'b01,1'b0,5'd0, 5'b00000},
    {2'b01,1'b1,5'd3, 2'b00, 2'b01,1'b0,5'd3, 2'b00, 2'b00,1'b1,5'd0, 3'b000, 2'b00,1'b1,5'd0, 5'b00000},
    {2'b01,1'b0,5'd7, 2'b10, 2'b01,1'b0,5'd7, 2'b10, 2'b01,1'b0,5'd0, 3'b001, 2'b01,1'b0,5'd0, 5'b00100},
    {2'b01,1'b0,5'd7, 2'b00, 2'b01,1'b0,5'd7, 2'b00, 2'b00,1'b0,5'd0, 3'b000, 2'b00,1'b0,5'd0, 5'b00000},
    {2'b00,1'b0,5'd9, 2'b11, 2'b01,1'b1,5'd20,2'b01, 2'b00,1'b1,5'd0, 3'b000, 2'b00,1'b1,5'd0, 5'b00000},
    {2'b00,1'b0,5'd0, 2'b00, 2'b10,1'b0,5'd0, 2'b00, 2'b11,1'b0,5'd0, 3'b000, 2'b11,1'b0,5'd0, 5'b00000},
    {2'b11,1'b0,5'd4, 2'b01, 2'b00,1'b0,5'd0, 2'b00, 2'b11,1'b0,5'd0, 3'b000, 2'b11,1'b0,5'd0, 5'b00000},
    {2'b10,1'b0,5'd17,2'b10, 2'b01,1'b1,5'd2, 2'b01, 2'b10,1'b1,5'd0, 3'b000, 2'b10,1'b1,5'd0, 5'b00000},
    {2'b01,1'b0,5'd15,2'b00, 2'b11,1'b1,5'd15,2'b00, 2'b11,1'b1,5'd0, 3'b000, 2'b11,1'b1,5'd0, 5'b00000}
  };

  localparam string TAGS [NV] = '{
    "R1 R2 unit", "R2 R3 norm", "R2 R3 norm", "R3 R10 round up",
    "R3 tie even", "R3 R10 tie even", "R6 overflow", "R7 max exp",
    "R6 norm overflow", "R7 zero exp", "R7 R10 underflow", "R7 norm rescue",
    "R7 underflow by one", "R9 zero operand ignored", "R8 zero x inf",
    "R8 nan x zero", "R9 inf x normal", "R8 R10 normal x nan"
  };

  task automatic check(input string what, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    @(negedge clk);
    // R9: idle inputs are zero x zero, giving a cleared zero-class result
    check("R9 idle zero", {2'b00, r_s}, 13'd0);
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      a = VEC[i][43:34];
      b = VEC[i][33:24];
      @(negedge clk);
      check({TAGS[i], " single"}, {2'b00, r_s}, {2'b00, VEC[i][23:13]});
      check({TAGS[i], " R5 extended"}, r_x, VEC[i][12:0]);
    end
    // R4: 1.125 x 1.75 = 1.96875, tie with odd lsb rounds up and carries into exponent
    @(posedge clk);
    a3 = {2'b01, 1'b0, 5'd15, 3'b001};
    b3 = {2'b01, 1'b0, 5'd15, 3'b110};
    @(negedge clk);
    check("R4 rounding carry", {1'b0, r_w}, {1'b0, 2'b01, 1'b0, 5'd16, 4'b0000});
    // R3: 1.125 x 1.125 = 1.265625, guard clear, truncates
    @(posedge clk);
    b3 = {2'b01, 1'b1, 5'd15, 3'b001};
    @(negedge clk);
    check("R3 R10 wide truncate", {1'b0, r_w}, {1'b0, 2'b01, 1'b1, 5'd15, 4'b0100});
    // R1: widths follow the configuration
    check("R1 single width", 13'($bits(r_s)), 13'd11);
    check("R1 extended width", 13'($bits(r_x)), 13'd13);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

endmodule